// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the system clock into the bit-level timing a CAN controller needs. A single 16-bit configuration word sets the prescaler, the jump width and the two timing segments. Each field is stored as its value minus one. A prescaler divides the clock into time-quantum ticks. A segment counter then walks every nominal bit through a one-quantum synchronization segment, a combined propagation and phase-1 stretch, and a phase-2 stretch. It raises a strobe at the start of each bit and another at the sample point.

The receive line is looked at once per quantum. A falling level, recessive (1) to dominant (0), while the bus is idle restarts the bit: this is hard synchronization. The same edge inside a running bit moves the sample point or the next bit start by the phase error, limited by the jump width. At most one such correction happens per bit. The controller asserts the init input while it writes a new word. A word that cannot form a legal bit raises an invalid flag and keeps the timing logic stopped.

Top module: `can_bit_timer`

## Requirements
- R1: The configuration word is captured only on clock edges where `init` is 1, with phase-2-minus-one in bits [14:12], sync-plus-prop-and-phase-1-minus-one in [11:8], jump-width-minus-one in [7:6] and prescaler-minus-one in [5:0]. Bit 15 and any change while `init` is 0 have no effect. The generator is held stopped while `init` is 1.
- R2: With prescaler field P, `tq_tick` pulses for one clock every P+1 clocks.
- R3: `bit_start` pulses on the tick that ends the synchronization quantum. Without synchronization events, consecutive `bit_start` pulses are (T1+T2+3) quanta apart, where T1 is the [11:8] field and T2 is the [14:12] field.
- R4: `sample_stb` pulses on the tick that ends the last quantum before phase 2. Without resynchronization this is T1+1 quanta after `bit_start`. It never coincides with `bit_start`.
- R5: `sample_bit` takes the value of `rx` at the clock edge where `sample_stb` is 1. It is 1 after reset.
- R6: A word with T2 = 0 (phase 2 below two quanta, or a bit below four quanta) sets `cfg_invalid`, and then no `tq_tick` occurs.
- R7: A falling edge is a tick at which `rx` is 0 after being 1 at the previous tick. A falling edge while `bus_idle` is 1 gives `bit_start` on that same tick. The sample point follows T1+1 quanta later.
- R8: A falling edge at quantum k (k = 0 first) of the pre-sample stretch, with `bus_idle` 0, delays the sample point by min(k+1, J) quanta, where J is the [7:6] field plus one.
- R9: A falling edge at quantum k of phase 2 (length L2 = T2+1), with `bus_idle` 0, has phase error e = L2-k. If e <= J, `bit_start` pulses on that tick. Otherwise phase 2 is shortened by J quanta.
- R10: Only the first falling edge in a bit's pre-sample or phase-2 stretch resynchronizes. Later edges in the same bit are ignored.
- R11: After reset the stored word is 0, so `cfg_invalid` is 1, no strobe pulses, and `sample_bit` is 1.
- R12: The word 0x6FC0 with prescaler field 0 gives a 24-clock bit, with the sample point 16 quanta after `bit_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Configuration load enable; holds the generator stopped |
| cfg_word | input | 16 | Packed timing configuration |
| rx | input | 1 | Receive line level (1 = recessive) |
| bus_idle | input | 1 | High while the bus is idle; selects hard synchronization |
| tq_tick | output | 1 | One-clock pulse per time quantum |
| bit_start | output | 1 | Pulse at the end of a bit's synchronization quantum |
| sample_stb | output | 1 | Pulse at the sample point |
| sample_bit | output | 1 | Receive level captured at the sample point |
| cfg_invalid | output | 1 | Stored configuration cannot form a legal bit |

## Verification
Some rules hold on every cycle, and the assertions track these. Both strobes fall only on quantum ticks and never together. No tick appears while the word is invalid. Ticks are spaced out when the prescaler is above one. The sampled bit always follows the line level at the sample strobe. Bit length, sample position and the effects of hard synchronization and resynchronization depend on where an edge lands within a bit. Only the bench's scenarios show these, because they place edges at chosen quanta and compare strobe distances with values computed from the fields.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    localparam int CFG_W = 16;
    localparam int BRP_W = 6;
    localparam int SJW_W = 2;
    localparam int TS1_W = 4;
    localparam int TS2_W = 3;
    localparam int Q_W   = 5;   // quantum index inside a segment (up to 20)
    localparam int JW_W  = SJW_W + 1;

    localparam logic [Q_W-1:0] MIN_BIT_Q = 5'd4;

    // bit layout: [14:12] phase2-1, [11:8] seg1-1, [7:6] jump-1, [5:0] prescale-1
    typedef struct packed {
        logic [TS2_W-1:0] tseg2;
        logic [TS1_W-1:0] tseg1;
        logic [SJW_W-1:0] sjw_m1;
        logic [BRP_W-1:0] brp_m1;
    } cfg_t;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_TS1  = 2'd1,
        SEG_TS2  = 2'd2
    } seg_e;

    function automatic logic [Q_W-1:0] bit_quanta(cfg_t c);
        return 5'd3 + {1'b0, c.tseg1} + {2'b00, c.tseg2};
    endfunction

    function automatic logic cfg_ok(cfg_t c);
        return (bit_quanta(c) >= MIN_BIT_Q) && (c.tseg2 != '0);
    endfunction

    function automatic logic [JW_W-1:0] jump_width(logic [SJW_W-1:0] f);
        return {1'b0, f} + 3'd1;
    endfunction

    function automatic logic [Q_W-1:0] qmin(logic [Q_W-1:0] a, logic [Q_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic [CFG_W-1:0] cfg_word,
    output cfg_t             cfg_q,
    output logic             invalid
);
    localparam int USED_W = $bits(cfg_t);

    logic [CFG_W-USED_W-1:0] cfg_unused;
    assign cfg_unused = cfg_word[CFG_W-1:USED_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (init) begin
            cfg_q <= cfg_t'(cfg_word[USED_W-1:0]);
        end
    end

    assign invalid = !cfg_ok(cfg_q);
endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          hold,
    input  logic [CW-1:0] div_m1,
    output logic          tick
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (hold) begin
            cnt <= '0;
        end else if (cnt == div_m1) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = !hold && (cnt == div_m1);
endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
    input  logic clk,
    input  logic hold,
    input  logic tick,
    input  logic rx,
    output logic fall
);
    logic rx_at_tick;

    always_ff @(posedge clk) begin
        if (hold) begin
            rx_at_tick <= 1'b1;
        end else if (tick) begin
            rx_at_tick <= rx;
        end
    end

    assign fall = tick && rx_at_tick && !rx;
endmodule

// File: rtl/can_bt_seg.sv
module can_bt_seg
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             hold,
    input  logic             tick,
    input  logic             fall,
    input  logic             bus_idle,
    input  logic [TS1_W-1:0] tseg1,
    input  logic [TS2_W-1:0] tseg2,
    input  logic [SJW_W-1:0] sjw_m1,
    output logic             bit_start,
    output logic             sample_stb
);
    seg_e           seg;
    logic [Q_W-1:0] qcnt;
    logic [Q_W-1:0] ext;      // phase-1 lengthening in quanta
    logic [Q_W-1:0] shr;      // phase-2 shortening in quanta
    logic           resynced;

    logic [Q_W-1:0] len1, len2, jw;
    logic           hard, resync;
    logic [Q_W-1:0] ext_n, shr_n, remain, ts1_last;
    logic           ts1_end, ts2_end, early_restart;

    always_comb begin
        len1 = {1'b0, tseg1} + 5'd1;
        len2 = {2'b00, tseg2} + 5'd1;
        jw   = {2'b00, jump_width(sjw_m1)};

        hard   = tick && fall && bus_idle;
        resync = tick && fall && !bus_idle && !resynced;

        ext_n = ext;
        if (resync && seg == SEG_TS1) begin
            ext_n = qmin(qcnt + 5'd1, jw);
        end
        ts1_last = len1 - 5'd1 + ext_n;
        ts1_end  = (qcnt == ts1_last);

        remain        = len2 - qcnt;
        early_restart = resync && (seg == SEG_TS2) && (remain <= jw);
        shr_n = shr;
        if (resync && seg == SEG_TS2 && !early_restart) begin
            shr_n = jw;
        end
        ts2_end = (qcnt + shr_n) >= (len2 - 5'd1);

        bit_start  = tick && ((seg == SEG_SYNC) || hard || early_restart);
        sample_stb = tick && (seg == SEG_TS1) && ts1_end && !hard;
    end

    always_ff @(posedge clk) begin
        if (hold) begin
            seg      <= SEG_SYNC;
            qcnt     <= '0;
            ext      <= '0;
            shr      <= '0;
            resynced <= 1'b0;
        end else if (tick) begin
            if (hard || early_restart || seg == SEG_SYNC) begin
                seg      <= SEG_TS1;
                qcnt     <= '0;
                ext      <= '0;
                shr      <= '0;
                resynced <= 1'b0;
            end else if (seg == SEG_TS1) begin
                resynced <= resynced | resync;
                ext      <= ext_n;
                if (ts1_end) begin
                    seg  <= SEG_TS2;
                    qcnt <= '0;
                end else begin
                    qcnt <= qcnt + 5'd1;
                end
            end else begin
                resynced <= resynced | resync;
                shr      <= shr_n;
                if (ts2_end) begin
                    seg  <= SEG_SYNC;
                    qcnt <= '0;
                end else begin
                    qcnt <= qcnt + 5'd1;
                end
            end
        end
    end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             rx,
    input  logic             bus_idle,
    output logic             tq_tick,
    output logic             bit_start,
    output logic             sample_stb,
    output logic             sample_bit,
    output logic             cfg_invalid
);
    cfg_t cfg_q;
    logic gen_hold;
    logic fall;

    can_bt_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .init     (init),
        .cfg_word (cfg_word),
        .cfg_q    (cfg_q),
        .invalid  (cfg_invalid)
    );

    assign gen_hold = rst || init || cfg_invalid;

    can_bt_prescaler #(.CW(BRP_W)) u_presc (
        .clk    (clk),
        .hold   (gen_hold),
        .div_m1 (cfg_q.brp_m1),
        .tick   (tq_tick)
    );

    can_bt_edge u_edge (
        .clk  (clk),
        .hold (gen_hold),
        .tick (tq_tick),
        .rx   (rx),
        .fall (fall)
    );

    can_bt_seg u_seg (
        .clk        (clk),
        .hold       (gen_hold),
        .tick       (tq_tick),
        .fall       (fall),
        .bus_idle   (bus_idle),
        .tseg1      (cfg_q.tseg1),
        .tseg2      (cfg_q.tseg2),
        .sjw_m1     (cfg_q.sjw_m1),
        .bit_start  (bit_start),
        .sample_stb (sample_stb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_bit <= 1'b1;
        end else if (sample_stb) begin
            sample_bit <= rx;
        end
    end
endmodule

// File: rtl/can_bt_checker.sv
module can_bt_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx,
    input logic       tq_tick,
    input logic       bit_start,
    input logic       sample_stb,
    input logic       sample_bit,
    input logic       cfg_invalid,
    input logic [5:0] brp_m1
);
    assert_start_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        bit_start |-> tq_tick);

    assert_sample_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> tq_tick);

    assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bit_start, sample_stb}));

    assert_invalid_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_invalid |-> !tq_tick);

    assert_sample_capture_R5: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> (sample_bit == $past(rx)));

    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
        (tq_tick && brp_m1 != 6'd0) |=> !tq_tick);
endmodule

bind can_bit_timer can_bt_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx          (rx),
    .tq_tick     (tq_tick),
    .bit_start   (bit_start),
    .sample_stb  (sample_stb),
    .sample_bit  (sample_bit),
    .cfg_invalid (cfg_invalid),
    .brp_m1      (cfg_q.brp_m1)
);

// File: tb/sim_can_bit_timer.sv
module sim_can_bit_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_MAX   = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init = 1'b0;
    logic [15:0] cfg_word = '0;
    logic        rx = 1'b1;
    logic        bus_idle = 1'b0;
    logic        tq_tick, bit_start, sample_stb, sample_bit, cfg_invalid;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    can_bit_timer u0 (
        .clk(clk), .rst(rst), .init(init), .cfg_word(cfg_word), .rx(rx),
        .bus_idle(bus_idle), .tq_tick(tq_tick), .bit_start(bit_start),
        .sample_stb(sample_stb), .sample_bit(sample_bit), .cfg_invalid(cfg_invalid)
    );

    function automatic logic [15:0] mk_word(int t2, int t1, int j, int p);
        return 16'((t2 << 12) | (t1 << 8) | (j << 6) | p);
    endfunction
    function automatic int exp_bit(int t1, int t2, int p);
        return (p + 1) * (t1 + t2 + 3);
    endfunction
    function automatic int exp_samp(int t1, int p);
        return (p + 1) * (t1 + 1);
    endfunction

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic adv(logic r, logic idle);
        @(negedge clk);
        rx = r;
        bus_idle = idle;
        #1;
    endtask

    // sel: 0 tick, 1 bit_start, 2 sample_stb
    task automatic wait_for(int sel, output int t);
        t = -1;
        for (int i = 0; i < WAIT_MAX; i++) begin
            adv(rx, bus_idle);
            if ((sel == 0 && tq_tick) || (sel == 1 && bit_start) || (sel == 2 && sample_stb)) begin
                t = cyc;
                return;
            end
        end
        chk("wait timeout", 0, 1);
    endtask

    task automatic load(logic [15:0] w);
        @(negedge clk);
        cfg_word = w;
        init = 1'b1;
        @(negedge clk);
        @(negedge clk);
        init = 1'b0;
        #1;
    endtask

    task automatic measure(output int per, output int samp, output int tgap);
        int t0, t1, ts, ta, tb;
        wait_for(1, t0);
        wait_for(1, t0);
        wait_for(2, ts);
        wait_for(1, t1);
        wait_for(0, ta);
        wait_for(0, tb);
        per = t1 - t0;
        samp = ts - t0;
        tgap = tb - ta;
    endtask

    // mask bit i set: rx dominant i cycles after a bit_start
    task automatic edge_run(logic [31:0] mask, output int ts, output int tb);
        int b;
        ts = -1;
        tb = -1;
        wait_for(1, b);
        for (int i = 1; i < 26; i++) begin
            adv(!mask[i], 1'b0);
            if (sample_stb && ts < 0) ts = i;
            if (bit_start && tb < 0) tb = i;
        end
        adv(1'b1, 1'b0);
    endtask

    initial begin
        int per, samp, gap, ts, tb, h, t, zeros;
        void'($urandom(32'd20250611));

        // R11: reset state
        repeat (3) adv(1'b1, 1'b0);
        rst = 1'b0;
        zeros = 0;
        for (int i = 0; i < 10; i++) begin
            adv(1'b1, 1'b0);
            zeros += int'(tq_tick) + int'(bit_start) + int'(sample_stb);
        end
        chk("R11 invalid after reset", int'(cfg_invalid), 1);
        chk("R11 no strobes after reset", zeros, 0);
        chk("R11 sample_bit reset", int'(sample_bit), 1);

        // R12: reference word
        load(16'h6FC0);
        chk("R12 valid", int'(cfg_invalid), 0);
        measure(per, samp, gap);
        chk("R12 bit length", per, 24);
        chk("R12 sample offset", samp, 16);

        // R1: writes without init ignored, bit 15 ignored
        @(negedge clk);
        cfg_word = 16'h1042;
        repeat (5) adv(1'b1, 1'b0);
        measure(per, samp, gap);
        chk("R1 no load without init", per, 24);
        load(16'hEFC0);
        measure(per, samp, gap);
        chk("R1 bit15 ignored", per, 24);

        // R2 R3 R4 random configurations
        for (int k = 0; k < 10; k++) begin
            int t1, t2, j, p;
            t2 = 1 + int'($urandom % 7);
            t1 = int'($urandom % 16);
            j = int'($urandom % 4);
            p = int'($urandom % 4);
            load(mk_word(t2, t1, j, p) | 16'(($urandom % 2) << 15));
            measure(per, samp, gap);
            chk("R3 bit period", per, exp_bit(t1, t2, p));
            chk("R4 sample offset", samp, exp_samp(t1, p));
            chk("R2 tick spacing", gap, p + 1);
        end

        // R6: invalid word
        load(mk_word(0, 5, 1, 0));
        zeros = 0;
        for (int i = 0; i < 30; i++) begin
            adv(1'b1, 1'b0);
            zeros += int'(tq_tick);
        end
        chk("R6 invalid flag", int'(cfg_invalid), 1);
        chk("R6 no ticks", zeros, 0);

        // R5: sampled value
        load(16'h6FC0);
        wait_for(1, t);
        adv(1'b0, 1'b0);
        wait_for(2, t);
        adv(1'b0, 1'b0);
        chk("R5 sampled dominant", int'(sample_bit), 0);
        adv(1'b1, 1'b0);
        wait_for(2, t);
        adv(1'b1, 1'b0);
        chk("R5 sampled recessive", int'(sample_bit), 1);

        // R7: hard synchronization in phase 2
        wait_for(2, t);
        adv(1'b1, 1'b1);
        adv(1'b1, 1'b1);
        adv(1'b0, 1'b1);
        h = cyc;
        chk("R7 bit_start on edge", int'(bit_start), 1);
        wait_for(2, t);
        chk("R7 sample after hard sync", t - h, 16);
        adv(1'b1, 1'b0);

        // R8: late edges, T1=7 T2=3 J=2
        load(mk_word(3, 7, 1, 0));
        edge_run(32'h0000_1FFC, ts, tb);
        chk("R8 late edge sample", ts, 10);
        chk("R8 late edge next bit", tb, 15);
        edge_run(32'h0000_1FC0, ts, tb);
        chk("R8 capped sample", ts, 10);
        chk("R8 capped next bit", tb, 15);

        // R10: second edge ignored, J=4
        load(mk_word(3, 7, 3, 0));
        edge_run(32'h0000_1FF2, ts, tb);
        chk("R10 one resync sample", ts, 9);
        chk("R10 one resync next bit", tb, 14);

        // R9: early edges
        edge_run(32'h0000_F800, ts, tb);
        chk("R9 restart sample", ts, 8);
        chk("R9 immediate restart", tb, 11);
        load(mk_word(3, 7, 0, 0));
        edge_run(32'h0000_7C00, ts, tb);
        chk("R9 shrink sample", ts, 8);
        chk("R9 shortened phase 2", tb, 12);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule